// File: doc/BRIEF.md
# Receive Unit Command Controller

This block sits between a host-facing command register and a receive DMA engine. Each cycle it may accept one 3-bit receive-unit command together with a 32-bit general pointer. It keeps the state of the receive engine and checks whether the command is legal in that state. For a legal command it issues a single-cycle action strobe to the DMA, with the address that goes with it. An illegal command produces an error pulse instead and changes nothing.

The block also holds two configuration values. The first is a base register that direct-DMA redirects are offset from. The second is a header-size register. Loading the header size sets a sticky header-only mode, and that mode stays set until reset.

The DMA reports status events while reception runs: suspended, out of buffer descriptors, and suspended with no buffer descriptors. Each event moves the unit out of the running state into the matching waiting state. Specific resume commands then bring it back.

Every state and transition is named below. The states are IDLE (0), READY (1), SUSPENDED (2), NO_RES_NO_BD (3) and SUSP_NO_BD (4).

Top module: `rx_cmd_ctrl`

## Requirements
- R1: After reset the state is IDLE (0), the base register, header size and header mode are zero, and every strobe is low.
- R2: Command code 0 (no-op) causes no state change, no strobe and no error.
- R3: Command code 1 (start) is legal in every state except READY and moves the unit to READY. It raises `start_pulse` with `rfa_addr` equal to the pointer. `fetch_bd_pulse` is raised together with it when `flex_mode` is high.
- R4: Command code 2 (resume) is legal only in SUSPENDED and moves the unit to READY with `resume_pulse`.
- R5: Command code 3 (redirect) is legal only while header mode is set. It moves the unit to READY and raises `redirect_pulse` with `redirect_addr` = base + pointer, modulo 2^32.
- R6: Command code 4 (abort) is legal in every state. It moves the unit to IDLE with `abort_pulse`.
- R7: Command code 5 loads the header size from pointer bits 13:0. The load is accepted only if that value is even and non-zero. It sets `hdr_mode`, which stays high until reset, and it does not change the state.
- R8: Command code 6 loads the full pointer into the base register in any state, without changing the state.
- R9: Command code 7 (buffer-descriptor resume) is legal only in NO_RES_NO_BD or SUSP_NO_BD. It moves the unit to READY with `bd_resume_pulse`.
- R10: The DMA events act only in READY and only in a cycle with no command. They take effect with this priority, highest first: `evt_no_bd` goes to NO_RES_NO_BD (3), `evt_susp_no_bd` goes to SUSP_NO_BD (4), and `evt_susp` goes to SUSPENDED (2).
- R11: A command that is illegal in the current state, including a rejected header-size load, raises `err_pulse`. It leaves the state, base, header size and header mode unchanged.
- R12: Strobes, addresses and register updates appear in the cycle after the command is sampled. Each strobe lasts one cycle, and at most one of start, resume, redirect, abort, buffer-descriptor resume and error is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Receive-unit command code |
| gen_ptr | input | 32 | General pointer accompanying the command |
| flex_mode | input | 1 | Flexible descriptor mode: start also prefetches a buffer descriptor |
| evt_susp | input | 1 | DMA event: suspended |
| evt_no_bd | input | 1 | DMA event: out of buffer descriptors |
| evt_susp_no_bd | input | 1 | DMA event: suspended with no buffer descriptors |
| ru_state | output | 3 | Current receive state code |
| start_pulse | output | 1 | Start and prefetch first frame descriptor |
| fetch_bd_pulse | output | 1 | Prefetch first buffer descriptor |
| rfa_addr | output | 32 | Frame area address, valid with start_pulse |
| resume_pulse | output | 1 | Resume reception |
| redirect_pulse | output | 1 | Restart direct-DMA reception |
| redirect_addr | output | 32 | Descriptor chain address, valid with redirect_pulse |
| abort_pulse | output | 1 | Stop reception |
| bd_resume_pulse | output | 1 | Resume after buffer-descriptor shortage |
| err_pulse | output | 1 | Command rejected |
| base_addr | output | 32 | Base register |
| hds_value | output | 14 | Header size register |
| hdr_mode | output | 1 | Sticky header-only mode |

## Verification
Every command code is applied in states where it is legal and in states where it is not. This separates a correct legality table from one that accepts or refuses too widely.

Header-size loads use an odd value, a zero value, and a pointer whose only set bits lie above bit 13. The last case shows whether the size field is cut out at the right width.

DMA events are applied one at a time, several at once, together with a command, and outside READY. This exposes errors in event priority and in gating.

The redirect uses a pointer that overflows when added to the base, which checks the modulo addition. Start is issued with flexible mode both off and on. Idle cycles after each action confirm that every strobe lasts exactly one cycle.

// File: rtl/rx_cmd_pkg.sv
package rx_cmd_pkg;

    typedef enum logic [2:0] {
        RU_IDLE       = 3'd0,
        RU_READY      = 3'd1,
        RU_SUSP       = 3'd2,
        RU_NORES_NOBD = 3'd3,
        RU_SUSP_NOBD  = 3'd4
    } ru_state_e;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_START     = 3'd1,
        OP_RESUME    = 3'd2,
        OP_REDIRECT  = 3'd3,
        OP_ABORT     = 3'd4,
        OP_LOAD_HDS  = 3'd5,
        OP_LOAD_BASE = 3'd6,
        OP_BD_RESUME = 3'd7
    } ru_op_e;

    typedef struct packed {
        logic start;
        logic resume;
        logic redirect;
        logic abort;
        logic bd_resume;
        logic ld_hds;
        logic ld_base;
    } ru_act_t;

endpackage

// File: rtl/rx_cmd_decode.sv
module rx_cmd_decode
    import rx_cmd_pkg::*;
#(
    parameter int HDS_W = 14
) (
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  ru_state_e        cur_state,
    input  logic             hdr_mode,
    input  logic [HDS_W-1:0] hds_field,
    output logic             accept,
    output logic             reject,
    output ru_act_t          act,
    output ru_state_e        next_state
);

    logic hds_ok;
    assign hds_ok = !hds_field[0] && (hds_field != '0);

    always_comb begin
        accept     = 1'b0;
        reject     = 1'b0;
        act        = '0;
        next_state = cur_state;
        if (cmd_valid) begin
            unique case (ru_op_e'(cmd_code))
                OP_NOP: accept = 1'b1;
                OP_START: begin
                    if (cur_state != RU_READY) begin
                        accept     = 1'b1;
                        act.start  = 1'b1;
                        next_state = RU_READY;
                    end else begin
                        reject = 1'b1;
                    end
                end
                OP_RESUME: begin
                    if (cur_state == RU_SUSP) begin
                        accept     = 1'b1;
                        act.resume = 1'b1;
                        next_state = RU_READY;
                    end else begin
                        reject = 1'b1;
                    end
                end
                OP_REDIRECT: begin
                    if (hdr_mode) begin
                        accept       = 1'b1;
                        act.redirect = 1'b1;
                        next_state   = RU_READY;
                    end else begin
                        reject = 1'b1;
                    end
                end
                OP_ABORT: begin
                    accept     = 1'b1;
                    act.abort  = 1'b1;
                    next_state = RU_IDLE;
                end
                OP_LOAD_HDS: begin
                    if (hds_ok) begin
                        accept     = 1'b1;
                        act.ld_hds = 1'b1;
                    end else begin
                        reject = 1'b1;
                    end
                end
                OP_LOAD_BASE: begin
                    accept      = 1'b1;
                    act.ld_base = 1'b1;
                end
                OP_BD_RESUME: begin
                    if (cur_state == RU_NORES_NOBD || cur_state == RU_SUSP_NOBD) begin
                        accept        = 1'b1;
                        act.bd_resume = 1'b1;
                        next_state    = RU_READY;
                    end else begin
                        reject = 1'b1;
                    end
                end
                default: reject = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rx_cmd_cfg.sv
module rx_cmd_cfg #(
    parameter int ADDR_W = 32,
    parameter int HDS_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_base,
    input  logic              ld_hds,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] base_q,
    output logic [HDS_W-1:0]  hds_q,
    output logic              hdr_mode_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            hds_q      <= '0;
            hdr_mode_q <= 1'b0;
        end else begin
            if (ld_base) begin
                base_q <= ptr;
            end
            if (ld_hds) begin
                hds_q      <= ptr[HDS_W-1:0];
                hdr_mode_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_cmd_ctrl.sv
module rx_cmd_ctrl
    import rx_cmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HDS_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] gen_ptr,
    input  logic              flex_mode,
    input  logic              evt_susp,
    input  logic              evt_no_bd,
    input  logic              evt_susp_no_bd,
    output logic [2:0]        ru_state,
    output logic              start_pulse,
    output logic              fetch_bd_pulse,
    output logic [ADDR_W-1:0] rfa_addr,
    output logic              resume_pulse,
    output logic              redirect_pulse,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              abort_pulse,
    output logic              bd_resume_pulse,
    output logic              err_pulse,
    output logic [ADDR_W-1:0] base_addr,
    output logic [HDS_W-1:0]  hds_value,
    output logic              hdr_mode
);

    ru_state_e state_q, state_d, dec_next;
    logic      dec_accept, dec_reject;
    ru_act_t   dec_act;

    rx_cmd_decode #(.HDS_W(HDS_W)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cur_state (state_q),
        .hdr_mode  (hdr_mode),
        .hds_field (gen_ptr[HDS_W-1:0]),
        .accept    (dec_accept),
        .reject    (dec_reject),
        .act       (dec_act),
        .next_state(dec_next)
    );

    rx_cmd_cfg #(.ADDR_W(ADDR_W), .HDS_W(HDS_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_base   (dec_act.ld_base),
        .ld_hds    (dec_act.ld_hds),
        .ptr       (gen_ptr),
        .base_q    (base_addr),
        .hds_q     (hds_value),
        .hdr_mode_q(hdr_mode)
    );

    // next state: an accepted command wins; events only while running and idle on the command port
    always_comb begin
        state_d = state_q;
        if (dec_accept) begin
            state_d = dec_next;
        end else if (!cmd_valid && state_q == RU_READY) begin
            if (evt_no_bd) begin
                state_d = RU_NORES_NOBD;
            end else if (evt_susp_no_bd) begin
                state_d = RU_SUSP_NOBD;
            end else if (evt_susp) begin
                state_d = RU_SUSP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RU_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign ru_state = state_q;

    // registered action outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse     <= 1'b0;
            fetch_bd_pulse  <= 1'b0;
            resume_pulse    <= 1'b0;
            redirect_pulse  <= 1'b0;
            abort_pulse     <= 1'b0;
            bd_resume_pulse <= 1'b0;
            err_pulse       <= 1'b0;
            rfa_addr        <= '0;
            redirect_addr   <= '0;
        end else begin
            start_pulse     <= dec_act.start;
            fetch_bd_pulse  <= dec_act.start && flex_mode;
            resume_pulse    <= dec_act.resume;
            redirect_pulse  <= dec_act.redirect;
            abort_pulse     <= dec_act.abort;
            bd_resume_pulse <= dec_act.bd_resume;
            err_pulse       <= dec_reject;
            if (dec_act.start) begin
                rfa_addr <= gen_ptr;
            end
            if (dec_act.redirect) begin
                redirect_addr <= base_addr + gen_ptr;
            end
        end
    end

endmodule

// File: rtl/rx_cmd_ctrl_chk.sv
module rx_cmd_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int HDS_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] gen_ptr,
    input logic [2:0]        ru_state,
    input logic              start_pulse,
    input logic              fetch_bd_pulse,
    input logic [ADDR_W-1:0] rfa_addr,
    input logic              resume_pulse,
    input logic              redirect_pulse,
    input logic              abort_pulse,
    input logic              bd_resume_pulse,
    input logic              err_pulse,
    input logic [HDS_W-1:0]  hds_value,
    input logic              hdr_mode
);

    assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd0) |=> (!err_pulse && ru_state == $past(ru_state)));

    assert_start_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (rfa_addr == $past(gen_ptr) && ru_state == 3'd1));

    assert_fetch_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_bd_pulse |-> start_pulse);

    assert_resume_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(ru_state) == 3'd2 && ru_state == 3'd1));

    assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> ru_state == 3'd0);

    assert_hdr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_mode |=> hdr_mode);

    assert_hds_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_mode |-> (!hds_value[0] && hds_value != '0));

    assert_bd_resume_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bd_resume_pulse |-> (($past(ru_state) == 3'd3 || $past(ru_state) == 3'd4) && ru_state == 3'd1));

    assert_state_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ru_state <= 3'd4);

    assert_reject_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ru_state == $past(ru_state));

    assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, resume_pulse, redirect_pulse, abort_pulse, bd_resume_pulse, err_pulse}));

    assert_start_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

endmodule

bind rx_cmd_ctrl rx_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .HDS_W(HDS_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_code       (cmd_code),
    .gen_ptr        (gen_ptr),
    .ru_state       (ru_state),
    .start_pulse    (start_pulse),
    .fetch_bd_pulse (fetch_bd_pulse),
    .rfa_addr       (rfa_addr),
    .resume_pulse   (resume_pulse),
    .redirect_pulse (redirect_pulse),
    .abort_pulse    (abort_pulse),
    .bd_resume_pulse(bd_resume_pulse),
    .err_pulse      (err_pulse),
    .hds_value      (hds_value),
    .hdr_mode       (hdr_mode)
);

// File: tb/rx_cmd_ctrl_test.sv
`timescale 1ns/1ps
module rx_cmd_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic [31:0] gen_ptr = '0;
    logic        flex_mode = 1'b0;
    logic        evt_susp = 1'b0;
    logic        evt_no_bd = 1'b0;
    logic        evt_susp_no_bd = 1'b0;
    logic [2:0]  ru_state;
    logic        start_pulse, fetch_bd_pulse, resume_pulse, redirect_pulse;
    logic        abort_pulse, bd_resume_pulse, err_pulse, hdr_mode;
    logic [31:0] rfa_addr, redirect_addr, base_addr;
    logic [13:0] hds_value;

    always #4 clk = ~clk;

    rx_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .gen_ptr(gen_ptr), .flex_mode(flex_mode), .evt_susp(evt_susp),
        .evt_no_bd(evt_no_bd), .evt_susp_no_bd(evt_susp_no_bd),
        .ru_state(ru_state), .start_pulse(start_pulse), .fetch_bd_pulse(fetch_bd_pulse),
        .rfa_addr(rfa_addr), .resume_pulse(resume_pulse), .redirect_pulse(redirect_pulse),
        .redirect_addr(redirect_addr), .abort_pulse(abort_pulse),
        .bd_resume_pulse(bd_resume_pulse), .err_pulse(err_pulse),
        .base_addr(base_addr), .hds_value(hds_value), .hdr_mode(hdr_mode)
    );

    // pulse vector order: start, fetch_bd, resume, redirect, abort, bd_resume, err
    typedef struct packed {
        logic [2:0]  st;
        logic [6:0]  pul;
        logic [31:0] rfa;
        logic [31:0] rdr;
        logic [31:0] base;
        logic [13:0] hds;
        logic        hdr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail = 0;

    logic [2:0]  m_state = 3'd0;
    logic [31:0] m_base = '0;
    logic [13:0] m_hds = '0;
    logic        m_hdr = 1'b0;

    task automatic step(input logic v, input logic [2:0] code, input logic [31:0] ptr,
                        input logic flex, input logic [2:0] evts, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = v; cmd_code = code; gen_ptr = ptr; flex_mode = flex;
        {evt_no_bd, evt_susp_no_bd, evt_susp} = evts;
        e = '0;
        if (v) begin
            case (code)
                3'd0: ;
                3'd1: if (m_state != 3'd1) begin
                          m_state = 3'd1; e.pul[6] = 1'b1; e.pul[5] = flex; e.rfa = ptr;
                      end else e.pul[0] = 1'b1;
                3'd2: if (m_state == 3'd2) begin m_state = 3'd1; e.pul[4] = 1'b1; end
                      else e.pul[0] = 1'b1;
                3'd3: if (m_hdr) begin
                          m_state = 3'd1; e.pul[3] = 1'b1; e.rdr = m_base + ptr;
                      end else e.pul[0] = 1'b1;
                3'd4: begin m_state = 3'd0; e.pul[2] = 1'b1; end
                3'd5: if (ptr[13:0] != 14'd0 && !ptr[0]) begin m_hds = ptr[13:0]; m_hdr = 1'b1; end
                      else e.pul[0] = 1'b1;
                3'd6: m_base = ptr;
                default: if (m_state == 3'd3 || m_state == 3'd4) begin
                          m_state = 3'd1; e.pul[1] = 1'b1;
                      end else e.pul[0] = 1'b1;
            endcase
        end else if (m_state == 3'd1) begin
            if (evts[2]) m_state = 3'd3;
            else if (evts[1]) m_state = 3'd4;
            else if (evts[0]) m_state = 3'd2;
        end
        e.st = m_state; e.base = m_base; e.hds = m_hds; e.hdr = m_hdr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 32'd0, 1'b0, 3'b000, tag);
    endtask

    // monitor: compares one expected item per cycle, 2 ns after the edge
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            logic  bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            bad = (ru_state != e.st) ||
                  ({start_pulse, fetch_bd_pulse, resume_pulse, redirect_pulse,
                    abort_pulse, bd_resume_pulse, err_pulse} != e.pul) ||
                  (base_addr != e.base) || (hds_value != e.hds) || (hdr_mode != e.hdr) ||
                  (e.pul[6] && rfa_addr != e.rfa) || (e.pul[3] && redirect_addr != e.rdr);
            n_checks++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: got st=%0d pul=%b rfa=%h rdr=%h base=%h hds=%h hdr=%b exp st=%0d pul=%b rfa=%h rdr=%h base=%h hds=%h hdr=%b",
                         t, ru_state,
                         {start_pulse, fetch_bd_pulse, resume_pulse, redirect_pulse,
                          abort_pulse, bd_resume_pulse, err_pulse},
                         rfa_addr, redirect_addr, base_addr, hds_value, hdr_mode,
                         e.st, e.pul, e.rfa, e.rdr, e.base, e.hds, e.hdr);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_checks++;
        if (ru_state != 3'd0 || base_addr != 0 || hds_value != 0 || hdr_mode ||
            start_pulse || resume_pulse || redirect_pulse || abort_pulse ||
            bd_resume_pulse || err_pulse || fetch_bd_pulse) begin
            n_fail++;
            $display("FAIL R1: got st=%0d base=%h hds=%h hdr=%b exp all zero",
                     ru_state, base_addr, hds_value, hdr_mode);
        end

        step(1, 3'd0, 32'hFFFF_FFFF, 0, 3'b000, "R2 nop idle");
        step(1, 3'd2, 32'd0, 0, 3'b000, "R4 R11 resume in idle");
        step(1, 3'd7, 32'd0, 0, 3'b000, "R9 R11 bd resume in idle");
        step(1, 3'd3, 32'h40, 0, 3'b000, "R5 R11 redirect without header mode");
        step(1, 3'd6, 32'h1000_0000, 0, 3'b000, "R8 load base");
        step(1, 3'd5, 32'd5, 0, 3'b000, "R7 R11 odd header size");
        step(1, 3'd5, 32'd0, 0, 3'b000, "R7 R11 zero header size");
        step(1, 3'd5, 32'h0000_4000, 0, 3'b000, "R7 R11 size bits above field");
        step(1, 3'd1, 32'h0000_00A0, 0, 3'b000, "R3 start no flex");
        idle("R12 start strobe ends");
        step(1, 3'd1, 32'h0000_00B0, 0, 3'b000, "R3 R11 start while ready");
        step(1, 3'd0, 32'd0, 0, 3'b111, "R2 R10 nop with events masks them");
        step(0, 3'd0, 32'd0, 0, 3'b001, "R10 suspend event");
        step(0, 3'd0, 32'd0, 0, 3'b110, "R10 event outside ready ignored");
        step(1, 3'd7, 32'd0, 0, 3'b000, "R9 R11 bd resume in suspended");
        step(1, 3'd2, 32'd0, 0, 3'b000, "R4 resume from suspended");
        step(0, 3'd0, 32'd0, 0, 3'b111, "R10 priority no bd");
        step(1, 3'd2, 32'd0, 0, 3'b000, "R4 R11 resume in no-bd state");
        step(1, 3'd7, 32'd0, 0, 3'b000, "R9 bd resume from no-bd");
        step(0, 3'd0, 32'd0, 0, 3'b011, "R10 priority susp no bd");
        step(1, 3'd6, 32'h2000_0000, 0, 3'b000, "R8 load base while waiting");
        step(1, 3'd7, 32'd0, 0, 3'b000, "R9 bd resume from susp no bd");
        step(1, 3'd5, 32'h0000_0100, 0, 3'b000, "R7 valid header size");
        step(1, 3'd4, 32'd0, 0, 3'b000, "R6 abort from ready");
        step(0, 3'd0, 32'd0, 0, 3'b001, "R10 event in idle ignored");
        step(1, 3'd4, 32'd0, 0, 3'b000, "R6 abort in idle");
        step(1, 3'd1, 32'hCAFE_0000, 1, 3'b000, "R3 start with flex");
        step(0, 3'd0, 32'd0, 0, 3'b001, "R10 suspend again");
        step(1, 3'd4, 32'd0, 0, 3'b000, "R6 abort from suspended");
        step(1, 3'd6, 32'h1000_0000, 0, 3'b000, "R8 reload base");
        step(1, 3'd3, 32'hFFFF_F010, 0, 3'b000, "R5 redirect with wrap");
        idle("R12 redirect strobe ends");
        step(1, 3'd5, 32'd3, 0, 3'b000, "R7 R11 bad size keeps old size");
        step(1, 3'd3, 32'h0000_0020, 0, 3'b000, "R5 redirect while ready");
        idle("R12 quiet");
        idle("R12 quiet");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule